// File: doc/BRIEF.md
# Midplane Slot Control Register Block

This block is a small register file on a simple 32-bit read/write bus. It lets a processor pick one chassis slot and a function code by writing a selector register, then read back a status word for that slot: whether a card is plugged in, whether the slot has power, and the serial-EEPROM data-out bit of the selected card. Writing the selector with the power function also marks that slot as powered on. The flag stays set until reset.

The block also reports the slot number of its own board through an identification register. It gathers one interrupt request bit per slot into a single interrupt line. Per-slot presence inputs, the own-slot number and the EEPROM chip-select and data-out pins for the selected card come from the board around it. Reads return data one cycle after the request through a registered output.

Top module: `slot_ctl_regs`

## Requirements
- R1: A write to offset 0x44 loads the selector. The slot number is taken from bits 15:12 (slots are numbered from 1) and the function code from bits 11:8. All other bits of the written word have no effect on any later read.
- R2: A selector write with function code 2 and a slot from 1 to NUM_SLOTS sets that slot's powered-on flag, which stays set until reset. The same write naming slot 0 or a slot above NUM_SLOTS changes no flag.
- R3: Reading offset 0x4C with function 0 returns 0x1 when the selected slot has no card. When a card is present it returns 0x2 if the slot's powered-on flag is set or the slot equals the own-slot input, and 0x0 otherwise. Slot 0 and slots above NUM_SLOTS count as empty.
- R4: Reading offset 0x4C with function 1 returns 0x1 for an empty slot and 0x0 for an occupied one.
- R5: Reading offset 0x4C with function 2 always returns 0x8 (power converter good).
- R6: Reading offset 0x4C with function 5 returns the EEPROM data-out bit in bit 0 while the EEPROM chip select is high, and 0 while it is low. Function codes 3, 4 and 6 to 15 read as 0.
- R7: Offset 0x04 reads as (own slot number << 8) | 0x80.
- R8: Each slot has one pending interrupt bit. A set pulse makes the bit 1 and a clear pulse makes it 0; set wins when both arrive together. irq_o is 1 in the cycle after any bit becomes set, and 0 once all bits are clear.
- R9: Offsets 0x0C, 0x14 and 0x1C read as 0 and offset 0x18 reads as 0x8000. Every other offset, including 0x44 and any address above 0xFF, reads as 0xFFFFFFFF. Writes to addresses other than 0x44 change nothing.
- R10: A read request produces rd_valid_o with its data exactly one cycle later. A write request produces no rd_valid_o.
- R11: Synchronous reset clears the selector to slot 0 and function 0, clears all powered-on flags and pending interrupt bits, and drops rd_valid_o and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Bus request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid (one cycle after a read request) |
| rd_data_o | output | 32 | Registered read data |
| card_present_i | input | NUM_SLOTS | Bit i high when slot i+1 holds a card |
| own_slot_i | input | 4 | Slot number of this board |
| eep_cs_i | input | 1 | Chip select of the selected card's EEPROM |
| eep_dout_i | input | 1 | Data-out of the selected card's EEPROM |
| irq_set_i | input | NUM_SLOTS | Per-slot interrupt set pulses |
| irq_clr_i | input | NUM_SLOTS | Per-slot interrupt clear pulses |
| irq_o | output | 1 | OR of all pending interrupt bits |

## Verification
The bench goes after selector writes that name slot 0 or slots 10 and 15 with function 2. A design that indexes without a range check would set a stray flag or wrap onto a real slot, and that shows up later as a wrong power-OK bit. It writes selector words with garbage outside the slot and function fields, and checks that the own slot reports power without its flag. A mis-placed field or a missing own-slot term would return the wrong status code. It also drives set and clear for one interrupt bit in the same cycle, clears one of two pending bits, and resets in the middle of the run. A clear-wins priority, a non-OR aggregate or flags that survive reset would each leave irq_o or the power bit wrong.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;

    localparam int SLOT_W = 4;
    localparam int FUNC_W = 4;
    localparam int DATA_W = 32;
    localparam int OFS_W  = 8;

    // Only the slot and function fields of the selector word steer behaviour.
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [FUNC_W-1:0] func;
    } sel_fields_t;

    typedef enum logic [FUNC_W-1:0] {
        FN_PRESENCE = 4'h0,
        FN_EMPTY    = 4'h1,
        FN_POWER    = 4'h2,
        FN_EEPROM   = 4'h5
    } slot_func_e;

    typedef enum logic [2:0] {
        RS_SLOT_ID,
        RS_ZERO,
        RS_CONST,
        RS_STATUS,
        RS_ALL_ONES
    } rd_src_e;

    localparam logic [OFS_W-1:0] OFS_SLOT_ID = 8'h04;
    localparam logic [OFS_W-1:0] OFS_ZERO_A  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_ZERO_B  = 8'h14;
    localparam logic [OFS_W-1:0] OFS_CONST   = 8'h18;
    localparam logic [OFS_W-1:0] OFS_ZERO_C  = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_SEL     = 8'h44;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 8'h4C;

    localparam logic [DATA_W-1:0] CONST_WORD    = 32'h0000_8000;
    localparam logic [DATA_W-1:0] PWR_CONV_GOOD = 32'h0000_0008;
    localparam logic [DATA_W-1:0] ALL_ONES      = 32'hFFFF_FFFF;

    function automatic rd_src_e decode_read(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_SLOT_ID:                        return RS_SLOT_ID;
            OFS_ZERO_A, OFS_ZERO_B, OFS_ZERO_C: return RS_ZERO;
            OFS_CONST:                          return RS_CONST;
            OFS_STATUS:                         return RS_STATUS;
            default:                            return RS_ALL_ONES;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_id_word(input logic [SLOT_W-1:0] own);
        return {{(DATA_W-SLOT_W-8){1'b0}}, own, 8'h80};
    endfunction

endpackage

// File: rtl/slot_sel_power.sv
module slot_sel_power
    import slot_ctl_pkg::*;
#(
    parameter int NUM_SLOTS = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_we,
    input  sel_fields_t          sel_wr,
    output sel_fields_t          sel_q,
    output logic [NUM_SLOTS-1:0] pwr_on_q
);

    localparam logic [SLOT_W-1:0] MAX_SLOT = SLOT_W'(NUM_SLOTS);

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else if (sel_we) sel_q <= sel_wr;
    end

    logic pwr_cmd;
    assign pwr_cmd = sel_we && (sel_wr.func == FN_POWER);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) pwr_on_q[i] <= 1'b0;
            else if (pwr_cmd && sel_wr.slot == SLOT_W'(i + 1)) pwr_on_q[i] <= 1'b1;
        end
    end

    AST_PWR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pwr_on_q & $past(pwr_on_q)) == $past(pwr_on_q)))
        else $error("powered-on flag dropped"); // R2

    AST_PWR_BAD_SLOT: assert property (@(posedge clk) disable iff (rst)
        (pwr_cmd && (sel_wr.slot == '0 || sel_wr.slot > MAX_SLOT)) |=> $stable(pwr_on_q))
        else $error("out-of-range slot touched a flag"); // R2

endmodule

// File: rtl/slot_irq_agg.sv
module slot_irq_agg #(
    parameter int NUM_SLOTS = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] set_i,
    input  logic [NUM_SLOTS-1:0] clr_i,
    output logic                 irq_o
);

    logic [NUM_SLOTS-1:0] pend_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst)           pend_q[i] <= 1'b0;
            else if (set_i[i]) pend_q[i] <= 1'b1;
            else if (clr_i[i]) pend_q[i] <= 1'b0;
        end
    end

    assign irq_o = |pend_q;

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> irq_o)
        else $error("set pulse did not raise interrupt"); // R8

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        ((&clr_i) && set_i == '0) |=> !irq_o)
        else $error("interrupt stayed with all bits cleared"); // R8

endmodule

// File: rtl/slot_status_mux.sv
module slot_status_mux
    import slot_ctl_pkg::*;
#(
    parameter int NUM_SLOTS = 9
) (
    input  sel_fields_t          sel,
    input  logic [NUM_SLOTS-1:0] present,
    input  logic [NUM_SLOTS-1:0] pwr_on,
    input  logic [SLOT_W-1:0]    own_slot,
    input  logic                 eep_cs,
    input  logic                 eep_dout,
    output logic [DATA_W-1:0]    status
);

    logic sel_present;
    logic sel_pwr;
    logic pwr_ok;

    always_comb begin
        sel_present = 1'b0;
        sel_pwr     = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sel.slot == SLOT_W'(i + 1)) begin
                sel_present = present[i];
                sel_pwr     = pwr_on[i];
            end
        end
    end

    assign pwr_ok = sel_pwr || (sel.slot == own_slot);

    always_comb begin
        case (slot_func_e'(sel.func))
            FN_PRESENCE: status = sel_present ? {{(DATA_W-2){1'b0}}, pwr_ok, 1'b0}
                                              : {{(DATA_W-1){1'b0}}, 1'b1};
            FN_EMPTY:    status = {{(DATA_W-1){1'b0}}, ~sel_present};
            FN_POWER:    status = PWR_CONV_GOOD;
            FN_EEPROM:   status = {{(DATA_W-1){1'b0}}, eep_cs & eep_dout};
            default:     status = '0;
        endcase
    end

endmodule

// File: rtl/slot_ctl_regs.sv
module slot_ctl_regs
    import slot_ctl_pkg::*;
#(
    parameter int NUM_SLOTS = 9,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [31:0]          req_wdata_i,
    output logic                 rd_valid_o,
    output logic [31:0]          rd_data_o,
    input  logic [NUM_SLOTS-1:0] card_present_i,
    input  logic [3:0]           own_slot_i,
    input  logic                 eep_cs_i,
    input  logic                 eep_dout_i,
    input  logic [NUM_SLOTS-1:0] irq_set_i,
    input  logic [NUM_SLOTS-1:0] irq_clr_i,
    output logic                 irq_o
);

    logic                 in_range;
    logic [OFS_W-1:0]     ofs;
    rd_src_e              src;
    logic                 rd_req;
    logic                 sel_we;
    sel_fields_t          sel_wr;
    sel_fields_t          sel_q;
    logic [NUM_SLOTS-1:0] pwr_on;
    logic [DATA_W-1:0]    status;
    logic [DATA_W-1:0]    rd_next;
    logic                 unused_wdata;

    assign in_range = (req_addr_i >> OFS_W) == '0;
    assign ofs      = req_addr_i[OFS_W-1:0];
    assign src      = in_range ? decode_read(ofs) : RS_ALL_ONES;
    assign rd_req   = req_valid_i && !req_write_i;
    assign sel_we   = req_valid_i && req_write_i && in_range && (ofs == OFS_SEL);
    assign sel_wr   = req_wdata_i[15:8];
    assign unused_wdata = ^{req_wdata_i[31:16], req_wdata_i[7:0]};

    slot_sel_power #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wr(sel_wr),
        .sel_q(sel_q), .pwr_on_q(pwr_on)
    );

    slot_status_mux #(.NUM_SLOTS(NUM_SLOTS)) u_mux (
        .sel(sel_q), .present(card_present_i), .pwr_on(pwr_on),
        .own_slot(own_slot_i), .eep_cs(eep_cs_i), .eep_dout(eep_dout_i),
        .status(status)
    );

    slot_irq_agg #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk(clk), .rst(rst), .set_i(irq_set_i), .clr_i(irq_clr_i), .irq_o(irq_o)
    );

    always_comb begin
        case (src)
            RS_SLOT_ID: rd_next = slot_id_word(own_slot_i);
            RS_ZERO:    rd_next = '0;
            RS_CONST:   rd_next = CONST_WORD;
            RS_STATUS:  rd_next = status;
            default:    rd_next = ALL_ONES;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_req;
            if (rd_req) rd_data_o <= rd_next;
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid_o)
        else $error("read not answered next cycle"); // R10

    AST_WR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_write_i) |=> !rd_valid_o)
        else $error("write produced read data"); // R10

    AST_PWR_CONV: assert property (@(posedge clk) disable iff (rst)
        (rd_req && in_range && ofs == OFS_STATUS && sel_q.func == FN_POWER)
            |=> rd_data_o == 32'h8)
        else $error("power function read wrong"); // R5

    AST_SLOT_ID: assert property (@(posedge clk) disable iff (rst)
        (rd_req && in_range && ofs == OFS_SLOT_ID) |=> rd_data_o[7:0] == 8'h80)
        else $error("slot id low byte wrong"); // R7

endmodule

// File: tb/slot_ctl_regs_tb_top.sv
module slot_ctl_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic [N-1:0] card_present = 9'b1_0000_0101;   // slots 1, 3, 9
    logic [3:0]   own_slot = 4'd3;
    logic         eep_cs = 1'b0;
    logic         eep_dout = 1'b0;
    logic [N-1:0] irq_set = '0;
    logic [N-1:0] irq_clr = '0;
    logic         irq;

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_ctl_regs #(.NUM_SLOTS(N), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .card_present_i(card_present), .own_slot_i(own_slot),
        .eep_cs_i(eep_cs), .eep_dout_i(eep_dout),
        .irq_set_i(irq_set), .irq_clr_i(irq_clr), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_sel;
    bit        m_pwr[16];
    bit        m_pend[N];
    bit        m_rv;
    bit [31:0] m_rd;

    function automatic bit [31:0] model_status();
        int s = int'(m_sel[15:12]);
        int f = int'(m_sel[11:8]);
        bit pres = (s >= 1 && s <= N) ? card_present[s-1] : 1'b0;
        bit pok;
        if (s >= 1 && s <= N) pok = m_pwr[s-1] || (s == int'(own_slot));
        else pok = (s == int'(own_slot));
        if (f == 0) return pres ? (pok ? 32'h2 : 32'h0) : 32'h1;
        if (f == 1) return pres ? 32'h0 : 32'h1;
        if (f == 2) return 32'h8;
        if (f == 5) return (eep_cs && eep_dout) ? 32'h1 : 32'h0;
        return 32'h0;
    endfunction

    function automatic bit [31:0] model_read(input bit [7:0] a);
        if (a == 8'h04) return (32'(own_slot) << 8) | 32'h80;
        if (a == 8'h0C || a == 8'h14 || a == 8'h1C) return 32'h0;
        if (a == 8'h18) return 32'h8000;
        if (a == 8'h4C) return model_status();
        return 32'hFFFF_FFFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sel = '0;
            m_rv  = 1'b0;
            for (int i = 0; i < 16; i++) m_pwr[i] = 1'b0;
            for (int i = 0; i < N; i++) m_pend[i] = 1'b0;
        end else begin
            m_rv = req_valid && !req_write;
            if (m_rv) m_rd = model_read(req_addr);
            if (req_valid && req_write && req_addr == 8'h44) begin
                int s;
                m_sel = req_wdata;
                s = int'(req_wdata[15:12]);
                if (req_wdata[11:8] == 4'h2 && s >= 1 && s <= N) m_pwr[s-1] = 1'b1;
            end
            for (int i = 0; i < N; i++) begin
                if (irq_set[i]) m_pend[i] = 1'b1;
                else if (irq_clr[i]) m_pend[i] = 1'b0;
            end
        end
    end

    function automatic bit model_irq();
        for (int i = 0; i < N; i++) if (m_pend[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check({cur_tag, " rd_valid"}, 32'(rd_valid), 32'(m_rv));
            if (m_rv) check({cur_tag, " rd_data"}, rd_data, m_rd);
            check({cur_tag, " irq"}, 32'(irq), 32'(model_irq()));
        end
    end

    // ---------------- stimulus tasks (called at a negedge) ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cur_tag = tag;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rd_valid), 32'h1);
        check(tag, rd_data, exp);
    endtask

    task automatic status_of(input logic [31:0] selw, input logic [31:0] exp, input string tag);
        wr(8'h44, selw);
        rd_expect(8'h4C, exp, tag);
    endtask

    task automatic irq_step(input logic [N-1:0] s, input logic [N-1:0] c,
                            input logic exp, input string tag);
        cur_tag = tag;
        irq_set = s; irq_clr = c;
        @(negedge clk);
        irq_set = '0; irq_clr = '0;
        check(tag, 32'(irq), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 rd_valid in reset", 32'(rd_valid), 32'h0);
        check("R11 irq in reset", 32'(irq), 32'h0);
        rst = 1'b0;
        rd_expect(8'h4C, 32'h1, "R11 selector resets to slot0 fn0");

        // R3 presence / power
        status_of(32'h0000_1000, 32'h0, "R3 slot1 present no power");
        status_of(32'h0000_3000, 32'h2, "R3 own slot powered");
        status_of(32'h0000_2000, 32'h1, "R3 slot2 empty");
        // R4
        status_of(32'h0000_2100, 32'h1, "R4 slot2 empty fn1");
        status_of(32'h0000_9100, 32'h0, "R4 slot9 occupied fn1");
        // R5 and R2 latch
        status_of(32'h0000_9200, 32'h8, "R5 power converter");
        status_of(32'h0000_9000, 32'h2, "R2 slot9 flag set");
        // R2 out-of-range slots leave flags alone
        wr(8'h44, 32'h0000_0200);
        wr(8'h44, 32'h0000_A200);
        wr(8'h44, 32'h0000_F200);
        status_of(32'h0000_1000, 32'h0, "R2 bad slots left slot1 flag");
        // R1 field positions with garbage elsewhere
        status_of(32'hDEAD_12FF, 32'h8, "R1 fields with garbage");
        status_of(32'hFFFF_10AA, 32'h2, "R1 slot1 fn0 after latch");
        // R6 EEPROM function
        eep_cs = 1'b0; eep_dout = 1'b1;
        status_of(32'h0000_1500, 32'h0, "R6 cs low");
        eep_cs = 1'b1;
        rd_expect(8'h4C, 32'h1, "R6 cs high dout 1");
        eep_dout = 1'b0;
        rd_expect(8'h4C, 32'h0, "R6 cs high dout 0");
        status_of(32'h0000_1300, 32'h0, "R6 unknown fn3");
        status_of(32'h0000_1F00, 32'h0, "R6 unknown fnF");
        // R7
        rd_expect(8'h04, 32'h0000_0380, "R7 slot id");
        // R9 fixed and unmapped
        rd_expect(8'h0C, 32'h0, "R9 zero 0x0C");
        rd_expect(8'h14, 32'h0, "R9 zero 0x14");
        rd_expect(8'h1C, 32'h0, "R9 zero 0x1C");
        rd_expect(8'h18, 32'h8000, "R9 const 0x18");
        rd_expect(8'h44, 32'hFFFF_FFFF, "R9 selector unreadable");
        rd_expect(8'h30, 32'hFFFF_FFFF, "R9 unmapped");
        status_of(32'h0000_2000, 32'h1, "R9 prep");
        wr(8'h48, 32'h0000_9000);
        rd_expect(8'h4C, 32'h1, "R9 write elsewhere ignored");
        // R10 back-to-back reads and write silence
        cur_tag = "R10";
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h18;
        @(negedge clk);
        check("R10 first read", rd_data, 32'h8000);
        req_addr = 8'h04;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 second read", rd_data, 32'h0000_0380);
        wr(8'h44, 32'h0000_1000);
        check("R10 write gives no valid", 32'(rd_valid), 32'h0);
        // R8 interrupts
        irq_step(9'b0_0000_1000, '0, 1'b1, "R8 set raises");
        irq_step('0, 9'b0_0000_1000, 1'b0, "R8 clear drops");
        irq_step(9'b1_0000_0001, '0, 1'b1, "R8 two set");
        irq_step('0, 9'b0_0000_0001, 1'b1, "R8 one cleared still high");
        irq_step(9'b0_0000_0010, 9'b1_0000_0010, 1'b1, "R8 set wins");
        irq_step('0, 9'b0_0000_0010, 1'b0, "R8 all clear");
        irq_step(9'b0_0001_0000, '0, 1'b1, "R11 prep irq");
        // R11 mid-run reset
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 irq cleared", 32'(irq), 32'h0);
        check("R11 rd_valid cleared", 32'(rd_valid), 32'h0);
        rst = 1'b0;
        status_of(32'h0000_9000, 32'h0, "R11 flag cleared");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule